// File: doc/BRIEF.md
# Interval counter channel

A single down-counting timer channel for a larger timer block. It holds one count of `W` bits and runs in one of six operating modes chosen by a 3-bit mode code: terminal-count flag, gate-triggered one-shot, periodic rate pulse, square wave, load-started strobe and gate-started strobe. The count steps down once per clock, either as a plain binary value or as packed decimal digits. The output line `out_o` follows the mode's waveform. The live count is visible on `cnt_o`.

A parent block writes the control word by pulsing `cw_wr` with `mode` and `bcd` valid. That pulse latches the settings and puts the channel in its idle state. The parent then pulses `ld` with a complete initial count on `ld_val`. In some modes the `gate` line acts as a level enable. In others it acts as a rising-edge trigger. Bus decoding, byte sequencing and count latching belong to the parent.

Top module: `ivl_chan`

## Requirements
- R1: After reset, `out_o` is 1, `cnt_o` is 0 and the channel is idle in mode 0. A `cw_wr` pulse latches `mode` and `bcd`. In the next cycle `cnt_o` is 0 and `out_o` is 0 for mode 0 and 1 for every other mode. The channel then stays idle until a load. An `ld` in the same cycle as `cw_wr` is ignored.
- R2: Mode codes 6 and 7 behave exactly like codes 2 and 3. Codes 4 and 5 keep their own modes.
- R3: Mode 0 (code 0): after a load of N, `cnt_o`=N and `out_o`=0. After N more clocks `cnt_o` reaches 0 and `out_o` rises. Both then hold until the next load or control word.
- R4: In codes 0, 2, 3 and 4, `gate`=0 freezes the count and `gate`=1 lets it resume.
- R5: Mode 1 (code 1): a `gate` rising edge that follows a load sets `cnt_o`=N and `out_o`=0 at that clock. `out_o` stays 0 for N clocks and returns to 1 when the count reaches 0. A rising edge seen before any load is ignored.
- R6: In mode 1, a load during a pulse changes neither the count nor the output. A later rising edge restarts the pulse from the newest loaded count.
- R7: Mode 2 (code 2): the output has period N. `out_o` is 0 for exactly the one clock in which `cnt_o`=1. On the next clock the count reloads to N and `out_o` returns to 1.
- R8: Mode 3 (code 3) counts like mode 2. Within each period of N, `out_o` is 1 for ceil(N/2) clocks and 0 for floor(N/2) clocks.
- R9: Mode 4 (code 4): a load sets `out_o`=1 and starts counting. When the count reaches 0, `out_o` is 0 for exactly one clock. It then stays 1 and counting stops.
- R10: Mode 5 (code 5): a load only arms the channel. A following `gate` rising edge starts a countdown from N with `out_o`=1, and the `gate` level is ignored after that. The count then ends with the same one-clock low strobe as mode 4.
- R11: With `bcd`=1, each 4-bit nibble of the count is one decimal digit, least significant digit in bits 3:0, and the count steps down in decimal (0x0010 to 0x0009, 0x0000 to 0x9999).
- R12: A loaded count of 0 stands for the largest count: 2^W clocks in binary, 10^(W/4) clocks in decimal.
- R13: In modes 2 and 3, a load while the channel is running only replaces the reload value. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate | input | 1 | Enable level or trigger edge, depending on the mode |
| mode | input | 3 | Mode code, sampled on `cw_wr` |
| bcd | input | 1 | 1 selects decimal counting, sampled on `cw_wr` |
| cw_wr | input | 1 | Control-word strobe: latches settings and idles the channel |
| ld | input | 1 | Load strobe for a new initial count |
| ld_val | input | W | Initial count carried by `ld` |
| out_o | output | 1 | Channel output waveform |
| cnt_o | output | W | Current count value |

## Verification
The properties assume the following about the inputs:
- `gate` is synchronous to `clk`.
- Every loaded value is valid decimal when decimal counting is selected.
- Counts of 1 are never used in the periodic modes.

The per-digit range property depends on the second point. Every decimal stimulus is built from digits 0 to 9. The periodic-mode cases load counts of 3 or more. The bench drives `gate`, `ld` and `cw_wr` only on the falling clock edge, so each strobe is seen at exactly one rising edge.

// File: rtl/ivl_pkg.sv
package ivl_pkg;

   typedef enum logic [2:0] {
      M_TCNT    = 3'd0,
      M_ONESHOT = 3'd1,
      M_RATE    = 3'd2,
      M_SQUARE  = 3'd3,
      M_SWSTB   = 3'd4,
      M_HWSTB   = 3'd5
   } mode_e;

   // Codes with bit 1 set ignore bit 2, so 6 and 7 fold onto 2 and 3.
   function automatic mode_e fold_mode(input logic [2:0] code);
      return mode_e'(code[1] ? {1'b0, code[1:0]} : code);
   endfunction

endpackage

// File: rtl/ivl_gate_edge.sv
module ivl_gate_edge #(
   parameter int SYNC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   output logic lvl_o,
   output logic rise_o
);

   logic prev_q;

   generate
      if (SYNC < 0) begin : g_bad
         $error("ivl_gate_edge: SYNC must not be negative");
      end
      if (SYNC == 0) begin : g_direct
         assign lvl_o = gate_i;
      end else begin : g_sync
         logic [SYNC-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= SYNC'({sh_q, gate_i});
         end
         assign lvl_o = sh_q[SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_o;
   end

   assign rise_o = lvl_o & ~prev_q;

endmodule

// File: rtl/ivl_dec.sv
module ivl_dec #(
   parameter int W = 16
) (
   input  logic [W-1:0] val_i,
   input  logic         bcd_i,
   output logic [W-1:0] dec_o
);

   localparam int ND = W / 4;

   logic [W-1:0] bin_v;
   logic [W-1:0] dig_v;
   logic [ND:0]  borrow;

   assign bin_v     = val_i - W'(1);
   assign borrow[0] = 1'b1;

   generate
      for (genvar i = 0; i < ND; i++) begin : g_dig
         logic [3:0] d;
         assign d = val_i[4*i +: 4];
         assign dig_v[4*i +: 4] = borrow[i] ? ((d == 4'd0) ? 4'd9 : d - 4'd1) : d;
         assign borrow[i+1]     = borrow[i] & (d == 4'd0);
      end
   endgenerate

   assign dec_o = bcd_i ? dig_v : bin_v;

endmodule

// File: rtl/ivl_half.sv
module ivl_half #(
   parameter int W = 16
) (
   input  logic [W-1:0] val_i,
   input  logic         bcd_i,
   output logic [W-1:0] half_o
);

   localparam int ND = W / 4;
   localparam logic [W-1:0] BIN_MAXH = W'(1) << (W - 1);
   localparam logic [W-1:0] BCD_MAXH = W'(5) << (W - 4);

   logic [W-1:0] bin_v;
   logic [W-1:0] dig_v;
   logic         zero;

   assign zero  = (val_i == '0);
   assign bin_v = val_i >> 1;

   generate
      for (genvar i = 0; i < ND; i++) begin : g_dig
         logic carry5;
         if (i == ND - 1) begin : g_top
            assign carry5 = 1'b0;
         end else begin : g_mid
            assign carry5 = val_i[4*(i+1)];
         end
         assign dig_v[4*i +: 4] = {1'b0, val_i[4*i+1 +: 3]} + (carry5 ? 4'd5 : 4'd0);
      end
   endgenerate

   always_comb begin
      if (bcd_i) half_o = zero ? BCD_MAXH : dig_v;
      else       half_o = zero ? BIN_MAXH : bin_v;
   end

endmodule

// File: rtl/ivl_chan.sv
module ivl_chan
   import ivl_pkg::*;
#(
   parameter int W    = 16,
   parameter int SYNC = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         gate,
   input  logic [2:0]   mode,
   input  logic         bcd,
   input  logic         cw_wr,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic         out_o,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] ONE = W'(1);

   generate
      if (W < 4 || (W % 4) != 0) begin : g_bad_w
         $error("ivl_chan: W must be a positive multiple of 4");
      end
   endgenerate

   mode_e        mode_r, mode_n;
   logic         bcd_r, bcd_n;
   logic [W-1:0] init_r, init_n;
   logic [W-1:0] per_r, per_n;
   logic [W-1:0] cnt_r, cnt_n;
   logic         out_r, out_n, out_f;
   logic         run_r, run_n;
   logic         armed_r, armed_n;
   logic         strb_r, strb_n;
   logic         sq_upd;
   logic         gate_lvl, gate_rise;
   logic [W-1:0] dec_v, half_v;
   logic         tc, en;

   ivl_gate_edge #(.SYNC(SYNC)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .gate_i(gate),
      .lvl_o (gate_lvl),
      .rise_o(gate_rise)
   );

   ivl_dec #(.W(W)) u_dec (
      .val_i(cnt_r),
      .bcd_i(bcd_r),
      .dec_o(dec_v)
   );

   ivl_half #(.W(W)) u_half (
      .val_i (per_n),
      .bcd_i (bcd_r),
      .half_o(half_v)
   );

   assign tc = (cnt_r == ONE);
   assign en = run_r & gate_lvl;

   always_comb begin
      mode_n  = mode_r;
      bcd_n   = bcd_r;
      init_n  = init_r;
      per_n   = per_r;
      cnt_n   = cnt_r;
      out_n   = out_r;
      run_n   = run_r;
      armed_n = armed_r;
      strb_n  = strb_r;
      sq_upd  = 1'b0;
      if (cw_wr) begin
         mode_n  = fold_mode(mode);
         bcd_n   = bcd;
         cnt_n   = '0;
         run_n   = 1'b0;
         armed_n = 1'b0;
         strb_n  = 1'b0;
         out_n   = (fold_mode(mode) != M_TCNT);
      end else begin
         unique case (mode_r)
            M_TCNT: begin
               if (ld) begin
                  init_n  = ld_val;
                  cnt_n   = ld_val;
                  out_n   = 1'b0;
                  run_n   = 1'b1;
                  armed_n = 1'b1;
               end else if (en) begin
                  if (tc) begin
                     cnt_n = '0;
                     out_n = 1'b1;
                     run_n = 1'b0;
                  end else begin
                     cnt_n = dec_v;
                  end
               end
            end
            M_ONESHOT, M_HWSTB: begin
               if (ld) begin
                  init_n  = ld_val;
                  armed_n = 1'b1;
               end
               if (gate_rise && armed_r) begin
                  cnt_n  = ld ? ld_val : init_r;
                  run_n  = 1'b1;
                  strb_n = 1'b0;
                  out_n  = (mode_r != M_ONESHOT);
               end else if (mode_r == M_ONESHOT) begin
                  if (run_r) begin
                     if (tc) begin
                        cnt_n = '0;
                        out_n = 1'b1;
                        run_n = 1'b0;
                     end else begin
                        cnt_n = dec_v;
                     end
                  end
               end else if (strb_r) begin
                  out_n  = 1'b1;
                  strb_n = 1'b0;
                  run_n  = 1'b0;
               end else if (run_r) begin
                  if (tc) begin
                     cnt_n  = '0;
                     out_n  = 1'b0;
                     strb_n = 1'b1;
                  end else begin
                     cnt_n = dec_v;
                  end
               end
            end
            M_SWSTB: begin
               if (ld) begin
                  init_n  = ld_val;
                  cnt_n   = ld_val;
                  out_n   = 1'b1;
                  run_n   = 1'b1;
                  armed_n = 1'b1;
                  strb_n  = 1'b0;
               end else if (strb_r) begin
                  out_n  = 1'b1;
                  strb_n = 1'b0;
                  run_n  = 1'b0;
               end else if (en) begin
                  if (tc) begin
                     cnt_n  = '0;
                     out_n  = 1'b0;
                     strb_n = 1'b1;
                  end else begin
                     cnt_n = dec_v;
                  end
               end
            end
            M_RATE, M_SQUARE: begin
               if (ld) begin
                  init_n  = ld_val;
                  armed_n = 1'b1;
                  if (!run_r) begin
                     cnt_n = ld_val;
                     per_n = ld_val;
                     run_n = 1'b1;
                     out_n = 1'b1;
                  end
               end
               if (en) begin
                  if (tc) begin
                     cnt_n = init_n;
                     per_n = init_n;
                  end else begin
                     cnt_n = dec_v;
                  end
                  if (mode_r == M_RATE) out_n = (cnt_n != ONE);
                  else                  sq_upd = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // Square wave: high while the remaining count is above half the period.
   always_comb begin
      if (sq_upd) out_f = (cnt_n == '0) || (cnt_n > half_v);
      else        out_f = out_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_r  <= M_TCNT;
         bcd_r   <= 1'b0;
         init_r  <= '0;
         per_r   <= '0;
         cnt_r   <= '0;
         out_r   <= 1'b1;
         run_r   <= 1'b0;
         armed_r <= 1'b0;
         strb_r  <= 1'b0;
      end else begin
         mode_r  <= mode_n;
         bcd_r   <= bcd_n;
         init_r  <= init_n;
         per_r   <= per_n;
         cnt_r   <= cnt_n;
         out_r   <= out_f;
         run_r   <= run_n;
         armed_r <= armed_n;
         strb_r  <= strb_n;
      end
   end

   assign out_o = out_r;
   assign cnt_o = cnt_r;

endmodule

// File: rtl/ivl_chan_chk.sv
module ivl_chan_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         gate,
   input logic         cw_wr,
   input logic         ld,
   input logic         out_o,
   input logic [W-1:0] cnt_o,
   input logic [2:0]   mode_q,
   input logic         bcd_q
);

   localparam int ND = W / 4;

   logic nib_ok;

   always_comb begin
      nib_ok = 1'b1;
      for (int i = 0; i < ND; i++) begin
         if (cnt_o[4*i +: 4] > 4'd9) nib_ok = 1'b0;
      end
   end

   AST_CW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cw_wr |=> (cnt_o == '0)) else $error("AST_CW_IDLE"); // R1

   AST_MODE_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_q[2] && mode_q[1])) else $error("AST_MODE_FOLD"); // R2

   AST_TC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'd0 && cnt_o == W'(1) && gate && !cw_wr && !ld) |=> out_o) else $error("AST_TC_RISE"); // R3

   AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 3'd0 || mode_q == 3'd2 || mode_q == 3'd3 || mode_q == 3'd4)
       && !gate && !cw_wr && !ld) |=> $stable(cnt_o)) else $error("AST_GATE_FREEZE"); // R4

   AST_RATE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'd2 && !out_o && gate && !cw_wr) |=> out_o) else $error("AST_RATE_PULSE"); // R7

   AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 3'd4 || mode_q == 3'd5) && !out_o && !cw_wr) |=> out_o) else $error("AST_STROBE_ONE"); // R9

   AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
      bcd_q |-> nib_ok) else $error("AST_BCD_DIGITS"); // R11

endmodule

bind ivl_chan ivl_chan_chk #(.W(W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .gate  (gate),
   .cw_wr (cw_wr),
   .ld    (ld),
   .out_o (out_o),
   .cnt_o (cnt_o),
   .mode_q(mode_r),
   .bcd_q (bcd_r)
);

// File: tb/sim_ivl_chan.sv
module sim_ivl_chan;

   localparam int CLK_P = 10;
   localparam int W     = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         gate = 1'b1;
   logic [2:0]   mode = '0;
   logic         bcd = 1'b0;
   logic         cw_wr = 1'b0;
   logic         ld = 1'b0;
   logic [W-1:0] ld_val = '0;
   logic         out_o;
   logic [W-1:0] cnt_o;

   int total = 0;
   int bad = 0;

   always #(CLK_P/2) clk = ~clk;

   ivl_chan #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .gate(gate), .mode(mode), .bcd(bcd),
      .cw_wr(cw_wr), .ld(ld), .ld_val(ld_val), .out_o(out_o), .cnt_o(cnt_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cw(input logic [2:0] m, input logic b);
      mode = m; bcd = b; cw_wr = 1'b1;
      tick(1);
      cw_wr = 1'b0;
   endtask

   task automatic load(input logic [W-1:0] v);
      ld_val = v; ld = 1'b1;
      tick(1);
      ld = 1'b0;
   endtask

   task automatic count_high(input int n, output int h);
      h = 0;
      for (int i = 0; i < n; i++) begin
         if (out_o) h++;
         tick(1);
      end
   endtask

   task automatic t_reset;
      chk("R1 reset out", out_o, 1);
      chk("R1 reset cnt", cnt_o, 0);
   endtask

   task automatic t_mode0;
      gate = 1'b1;
      cw(3'd0, 1'b0);
      chk("R1 cw mode0 out", out_o, 0);
      load(16'd5);
      chk("R3 load cnt", cnt_o, 5);
      chk("R3 load out", out_o, 0);
      tick(4);
      chk("R3 cnt1", cnt_o, 1);
      chk("R3 still low", out_o, 0);
      tick(1);
      chk("R3 tc cnt", cnt_o, 0);
      chk("R3 tc out", out_o, 1);
      tick(3);
      chk("R3 hold cnt", cnt_o, 0);
      chk("R3 hold out", out_o, 1);
   endtask

   task automatic t_gate;
      gate = 1'b1;
      cw(3'd0, 1'b0);
      load(16'd4);
      tick(1);
      chk("R4 before freeze", cnt_o, 3);
      gate = 1'b0;
      tick(3);
      chk("R4 frozen mode0", cnt_o, 3);
      gate = 1'b1;
      tick(1);
      chk("R4 resumed", cnt_o, 2);
      cw(3'd2, 1'b0);
      load(16'd5);
      gate = 1'b0;
      tick(2);
      chk("R4 frozen mode2", cnt_o, 5);
      gate = 1'b1;
      tick(1);
      chk("R4 resumed mode2", cnt_o, 4);
   endtask

   task automatic t_cw_ld;
      mode = 3'd4; bcd = 1'b0; ld_val = 16'd7; cw_wr = 1'b1; ld = 1'b1;
      tick(1);
      cw_wr = 1'b0; ld = 1'b0;
      chk("R1 cw+ld cnt", cnt_o, 0);
      chk("R1 cw mode4 out", out_o, 1);
      tick(3);
      chk("R1 ld ignored", cnt_o, 0);
   endtask

   task automatic t_mode1;
      gate = 1'b0;
      cw(3'd1, 1'b0);
      chk("R1 cw mode1 out", out_o, 1);
      gate = 1'b1;
      tick(2);
      chk("R5 early edge cnt", cnt_o, 0);
      chk("R5 early edge out", out_o, 1);
      gate = 1'b0;
      load(16'd3);
      chk("R5 load no start", cnt_o, 0);
      gate = 1'b1;
      tick(1);
      chk("R5 trig cnt", cnt_o, 3);
      chk("R5 trig out", out_o, 0);
      tick(2);
      chk("R5 cnt1 low", out_o, 0);
      tick(1);
      chk("R5 end out", out_o, 1);
      chk("R5 end cnt", cnt_o, 0);
   endtask

   task automatic t_retrig;
      gate = 1'b0;
      cw(3'd1, 1'b0);
      load(16'd4);
      gate = 1'b1;
      tick(1);
      chk("R6 trig", cnt_o, 4);
      gate = 1'b0;
      tick(1);
      load(16'd9);
      chk("R6 load no effect cnt", cnt_o, 2);
      chk("R6 load no effect out", out_o, 0);
      gate = 1'b1;
      tick(1);
      chk("R6 retrig newest", cnt_o, 9);
      chk("R6 still low", out_o, 0);
      tick(9);
      chk("R6 pulse end", out_o, 1);
   endtask

   task automatic t_mode2;
      gate = 1'b1;
      cw(3'd2, 1'b0);
      load(16'd3);
      chk("R7 load out", out_o, 1);
      tick(1);
      chk("R7 cnt2 high", out_o, 1);
      tick(1);
      chk("R7 cnt1 low", out_o, 0);
      chk("R7 cnt1", cnt_o, 1);
      tick(1);
      chk("R7 reload cnt", cnt_o, 3);
      chk("R7 reload high", out_o, 1);
   endtask

   task automatic t_alias;
      int h;
      gate = 1'b1;
      cw(3'd6, 1'b0);
      chk("R2 code6 out", out_o, 1);
      load(16'd3);
      tick(2);
      chk("R2 code6 low", out_o, 0);
      tick(1);
      chk("R2 code6 reload", cnt_o, 3);
      cw(3'd7, 1'b0);
      load(16'd5);
      count_high(5, h);
      chk("R2 code7 high count", h, 3);
   endtask

   task automatic t_mode3;
      int h;
      gate = 1'b1;
      cw(3'd3, 1'b0);
      load(16'd5);
      count_high(5, h);
      chk("R8 odd high", h, 3);
      chk("R8 odd reload", cnt_o, 5);
      cw(3'd3, 1'b0);
      load(16'd4);
      count_high(4, h);
      chk("R8 even high", h, 2);
      cw(3'd3, 1'b1);
      load(16'h0010);
      count_high(10, h);
      chk("R8 bcd high", h, 5);
      chk("R8 bcd reload", cnt_o, 16'h0010);
   endtask

   task automatic t_mode4;
      gate = 1'b1;
      cw(3'd4, 1'b0);
      load(16'd3);
      chk("R9 load out", out_o, 1);
      tick(2);
      chk("R9 before tc", out_o, 1);
      tick(1);
      chk("R9 strobe", out_o, 0);
      chk("R9 strobe cnt", cnt_o, 0);
      tick(1);
      chk("R9 after strobe", out_o, 1);
      tick(3);
      chk("R9 stopped out", out_o, 1);
      chk("R9 stopped cnt", cnt_o, 0);
   endtask

   task automatic t_mode5;
      gate = 1'b0;
      cw(3'd5, 1'b0);
      load(16'd2);
      chk("R10 load no start", cnt_o, 0);
      gate = 1'b1;
      tick(1);
      chk("R10 start cnt", cnt_o, 2);
      chk("R10 start out", out_o, 1);
      gate = 1'b0;
      tick(1);
      chk("R10 level ignored", cnt_o, 1);
      tick(1);
      chk("R10 strobe", out_o, 0);
      tick(1);
      chk("R10 after strobe", out_o, 1);
   endtask

   task automatic t_bcd;
      gate = 1'b1;
      cw(3'd4, 1'b1);
      load(16'h0010);
      tick(1);
      chk("R11 digit borrow", cnt_o, 16'h0009);
      cw(3'd0, 1'b1);
      load(16'h0000);
      tick(1);
      chk("R11 wrap 9999", cnt_o, 16'h9999);
      tick(9998);
      chk("R12 bcd max cnt1", cnt_o, 16'h0001);
      chk("R12 bcd max low", out_o, 0);
      tick(1);
      chk("R12 bcd max end", out_o, 1);
   endtask

   task automatic t_zero_bin;
      gate = 1'b1;
      cw(3'd0, 1'b0);
      load(16'h0000);
      chk("R12 zero start", cnt_o, 0);
      tick(1);
      chk("R12 bin wrap", cnt_o, 16'hFFFF);
      tick(65534);
      chk("R12 bin cnt1", cnt_o, 1);
      chk("R12 bin low", out_o, 0);
      tick(1);
      chk("R12 bin end", out_o, 1);
   endtask

   task automatic t_reload;
      gate = 1'b1;
      cw(3'd2, 1'b0);
      load(16'd4);
      tick(1);
      chk("R13 running", cnt_o, 3);
      load(16'd6);
      chk("R13 count kept", cnt_o, 2);
      tick(1);
      chk("R13 old period low", out_o, 0);
      tick(1);
      chk("R13 new reload", cnt_o, 6);
   endtask

   bit done = 1'b0;

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_mode0();
      t_gate();
      t_cw_ld();
      t_mode1();
      t_retrig();
      t_mode2();
      t_alias();
      t_mode3();
      t_mode4();
      t_mode5();
      t_bcd();
      t_zero_bin();
      t_reload();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 190000; i++) begin
         @(negedge clk);
         if (done) break;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule